// File: doc/BRIEF.md
# Mixed-Polarity Edge Interrupt Controller

This block turns transitions on twelve asynchronous port pins into latched interrupt flags and a single interrupt request line. Each pin has a fixed polarity. Seven pins respond only to rising edges and five respond only to falling edges. A pin is watched only while its source-enable bit is set. Each detected edge sets that pin's flag once. A flag raises the request only while its interrupt-enable bit is set and the processor's global interrupt-disable input is low.

Software uses a small register port for three tasks. It writes the source-enable and interrupt-enable registers, reads the flags, and clears flags by writing ones. Each pin passes through a two-flop synchronizer and then an edge comparator. An arming state machine keeps the comparator quiet until the synchronizer and the previous-sample register hold real pin history. The machine has two states. ARM_FILL is entered on reset and lasts three cycles. ARM_LIVE follows and holds until the next reset. The only transition, FILL_DONE, moves from ARM_FILL to ARM_LIVE when the fill counter reaches its last count.

Top module: `edgeirq_ctrl`

## Requirements
- R1: Sources 0 to 6 (polarity mask 12'h07F) are rising-edge sources: a 0-to-1 change on the pin sets the flag bit at that index.
- R2: On a rising-edge source, a 1-to-0 change leaves the flag unchanged.
- R3: Sources 7 to 11 are falling-edge sources: a 1-to-0 change sets the flag, and a 0-to-1 change leaves it unchanged.
- R4: A source whose source-enable bit (register address 2) is 0 never sets its flag.
- R5: irq_o is 1 only when at least one flag has its interrupt-enable bit (register address 1) set.
- R6: While gdis_i is 1, irq_o is 0 whatever the flags and enables are.
- R7: A flag is set once per edge. A level held on the pin does not set the flag again after software has cleared it.
- R8: A write to address 0 clears every flag whose data bit is 1 and leaves the others unchanged.
- R9: If an edge sets a flag in the same cycle that a write clears it, the flag ends up set.
- R10: A flag stays set while its interrupt-enable bit is 0. Writing the enable bit to 1 raises irq_o in the first cycle after the write.
- R11: Pin levels that are present during reset, or while the synchronizer is filling after reset, set no flag. After arming, a pin change that is applied before clock edge k shows up in the flags just after edge k+2.
- R12: Reads return the flags at address 0, the interrupt enables at address 1 and the source enables at address 2. All three are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 12 | Asynchronous source pins |
| gdis_i | input | 1 | Global interrupt disable from the processor |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 flags, 1 interrupt enable, 2 source enable |
| reg_wdata_i | input | 12 | Write data |
| reg_rdata_o | output | 12 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Internal state in this block is visible at the ports within a few cycles. A wrong previous-sample bit or a wrong arming state shows up as a spurious or missing flag in the read of address 0. That read happens three edges after the pin change that exposes the fault. A wrong flag or enable bit shows up on irq_o in the same cycle it exists, since the request path holds no register. A wrong clear-versus-set priority appears only in the single cycle where the two meet, so the bench aims one case at that exact edge.

// File: rtl/edgeirq_pkg.sv
package edgeirq_pkg;
    localparam int SRC_COUNT = 12;

    typedef enum logic [1:0] {
        SEL_FLAGS = 2'd0,
        SEL_IRQEN = 2'd1,
        SEL_SRCEN = 2'd2
    } reg_sel_e;

    typedef enum logic {
        ARM_FILL = 1'b0,
        ARM_LIVE = 1'b1
    } arm_state_e;
endpackage

// File: rtl/edgeirq_sync.sv
module edgeirq_sync #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/edgeirq_detect.sv
module edgeirq_detect
    import edgeirq_pkg::*;
#(
    parameter int           W           = 12,
    parameter logic [W-1:0] RISE_MASK   = 12'h07F,
    parameter int           FILL_CYCLES = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp_i,
    input  logic [W-1:0] src_en_i,
    output logic [W-1:0] edge_o
);
    localparam int CW = $clog2(FILL_CYCLES) + 1;

    arm_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [W-1:0]  prev_q;
    logic [W-1:0]  hit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARM_FILL;
            cnt_q   <= '0;
            prev_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            prev_q  <= smp_i;
        end
    end

    // Next state: FILL_DONE moves ARM_FILL to ARM_LIVE
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ARM_FILL: begin
                if (cnt_q == CW'(FILL_CYCLES - 1)) state_d = ARM_LIVE;
                else                               cnt_d   = cnt_q + 1'b1;
            end
            ARM_LIVE: begin
                state_d = ARM_LIVE;
            end
        endcase
    end

    // Per-source polarity chosen at elaboration
    for (genvar g = 0; g < W; g++) begin : g_src
        if (RISE_MASK[g]) begin : g_rise
            assign hit[g] = smp_i[g] & ~prev_q[g];
        end else begin : g_fall
            assign hit[g] = ~smp_i[g] & prev_q[g];
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ARM_FILL: edge_o = '0;
            ARM_LIVE: edge_o = hit & src_en_i;
        endcase
    end

    // R11: once armed, the detector never falls back to filling
    a_r11_stay_live: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARM_LIVE) |=> (state_q == ARM_LIVE));

    // R7: one pin change yields a single-cycle pulse
    a_r7_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((edge_o & $past(edge_o)) == '0));
endmodule

// File: rtl/edgeirq_flags.sv
module edgeirq_flags #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flag_o
);
    logic [W-1:0] flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_i) | set_i;
    end

    assign flag_o = flag_q;

    // R9: a set in the cycle of a clear still leaves the flag set
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & $past(set_i)) == $past(set_i)));

    // R8: a cleared flag with no competing set reads zero next cycle
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & $past(clr_i & ~set_i)) == '0));

    // R10: a flag never drops without a clear
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(flag_q) & ~$past(clr_i) & ~flag_q) == '0));
endmodule

// File: rtl/edgeirq_ctrl.sv
module edgeirq_ctrl
    import edgeirq_pkg::*;
#(
    parameter int                 N_SRC       = SRC_COUNT,
    parameter logic [N_SRC-1:0]   RISE_MASK   = 12'h07F,
    parameter int                 SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] pin_i,
    input  logic             gdis_i,
    input  logic             reg_wr_i,
    input  logic [1:0]       reg_addr_i,
    input  logic [N_SRC-1:0] reg_wdata_i,
    output logic [N_SRC-1:0] reg_rdata_o,
    output logic             irq_o
);
    localparam int FILL_CYCLES = SYNC_STAGES + 1;

    logic [N_SRC-1:0] smp, edges, flags, clr;
    logic [N_SRC-1:0] irq_en_q, src_en_q;

    edgeirq_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(smp)
    );

    edgeirq_detect #(.W(N_SRC), .RISE_MASK(RISE_MASK), .FILL_CYCLES(FILL_CYCLES)) det_i (
        .clk(clk), .rst_n(rst_n), .smp_i(smp), .src_en_i(src_en_q), .edge_o(edges)
    );

    assign clr = (reg_wr_i && reg_addr_i == SEL_FLAGS) ? reg_wdata_i : '0;

    edgeirq_flags #(.W(N_SRC)) flg_i (
        .clk(clk), .rst_n(rst_n), .set_i(edges), .clr_i(clr), .flag_o(flags)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en_q <= '0;
            src_en_q <= '0;
        end else if (reg_wr_i) begin
            if (reg_addr_i == SEL_IRQEN) irq_en_q <= reg_wdata_i;
            if (reg_addr_i == SEL_SRCEN) src_en_q <= reg_wdata_i;
        end
    end

    always_comb begin
        case (reg_addr_i)
            SEL_FLAGS: reg_rdata_o = flags;
            SEL_IRQEN: reg_rdata_o = irq_en_q;
            SEL_SRCEN: reg_rdata_o = src_en_q;
            default:   reg_rdata_o = '0;
        endcase
    end

    assign irq_o = (|(flags & irq_en_q)) & ~gdis_i;

    // R4: a source disabled in the previous cycle cannot raise its flag
    a_r4_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(src_en_q)) == '0));
endmodule

// File: tb/edgeirq_ctrl_tb.sv
module edgeirq_ctrl_tb_top;
    localparam int N = 12;
    localparam logic [N-1:0] RISE = 12'h07F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] pin = '0;
    logic gdis = 1'b0;
    logic wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [N-1:0] e_flags = '0, e_ien = '0, e_src = '0;

    always #4 clk = ~clk;

    edgeirq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .gdis_i(gdis),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [N-1:0] hits(input logic [N-1:0] o, input logic [N-1:0] n,
                                          input logic [N-1:0] en);
        return ((RISE & n & ~o) | (~RISE & o & ~n)) & en;
    endfunction

    function automatic logic exp_irq();
        return (|(e_flags & e_ien)) & ~gdis;
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wreg(input logic [1:0] a, input logic [N-1:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
        if (a == 2'd0) e_flags &= ~d;
        if (a == 2'd1) e_ien = d;
        if (a == 2'd2) e_src = d;
    endtask

    task automatic pins(input logic [N-1:0] v);
        e_flags |= hits(pin, v, e_src);
        pin = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_state(input string tag);
        logic [N-1:0] d;
        rd(2'd0, d);
        chk({tag, " flags"}, d, e_flags);
        chk({tag, " irq"}, {11'd0, irq}, {11'd0, exp_irq()});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [N-1:0] d;
        // R11: levels held through reset: rising pin 0 high, falling pin 9 high
        pin = 12'h201;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wreg(2'd2, '1);
        repeat (6) @(negedge clk);
        chk_state("R11 no flag from reset levels");
        wreg(2'd1, '1);
        rd(2'd1, d); chk("R12 irq enable readback", d, '1);
        rd(2'd2, d); chk("R12 source enable readback", d, '1);
        rd(2'd3, d); chk("R12 unused address", d, '0);

        pins(12'h200);                 // R2: pin 0 falls, no effect
        chk_state("R2 falling on rising source");
        pins(12'h201);                 // R1: pin 0 rises
        chk_state("R1 rising sets flag");
        chk("R5 irq with enabled flag", {11'd0, irq}, 12'd1);
        pins(12'h281);                 // R3: pin 7 rises, no effect
        chk_state("R3 rising on falling source");
        pins(12'h201);                 // R3: pin 7 falls
        chk_state("R3 falling sets flag");

        gdis = 1'b1; #1;
        chk("R6 gdis blocks irq", {11'd0, irq}, 12'd0);
        gdis = 1'b0; #1;

        wreg(2'd0, 12'h001);           // R8: clear bit 0 only
        chk_state("R8 selective clear");
        repeat (10) @(negedge clk);    // R7: pin 0 still high
        chk_state("R7 held level no reset of flag");
        wreg(2'd0, '1);
        chk_state("R8 clear all");
        chk("R5 no flags no irq", {11'd0, irq}, 12'd0);

        wreg(2'd2, 12'hFFD);           // R4: source 1 disabled
        pins(12'h203);
        chk_state("R4 disabled source ignored");

        wreg(2'd1, 12'h000);           // R10
        pins(12'h207);
        chk_state("R10 flag held while masked");
        wreg(2'd1, 12'h004);
        chk("R10 enable raises irq", {11'd0, irq}, 12'd1);
        chk_state("R10 state after enable");

        // R9: edge on pin 3 lands on the same edge as a clear of bit 3
        pins(12'h20F);
        pins(12'h207);
        pin = 12'h20F;
        @(negedge clk); @(negedge clk);
        wr = 1'b1; addr = 2'd0; wdata = 12'h008;
        @(negedge clk);
        wr = 1'b0;
        rd(2'd0, d);
        chk("R9 set wins over clear", d & 12'h008, 12'h008);
        e_flags |= 12'h008;
        repeat (2) @(negedge clk);

        for (int i = 0; i < 300; i++) begin
            int unsigned r;
            r = $urandom % 8;
            if (r == 0) wreg(2'd0, N'($urandom));
            else if (r == 1) wreg(2'd1, N'($urandom));
            else if (r == 2) wreg(2'd2, N'($urandom) | 12'hF0F);
            gdis = ($urandom % 4) == 0;
            pins(N'($urandom));
            chk_state($sformatf("R1 R3 R4 R5 R6 random %0d", i));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
    end
endmodule